// File: doc/BRIEF.md
# Cache-Inhibited Instruction Line Buffer

This block sits next to an instruction cache and handles reads to addresses that the cache must not hold. Such reads normally go to the external bus one at a time. When the buffer enable is set, the read is an instruction fetch and its transfer type is normal (zero), the block fetches the whole surrounding line in one burst and keeps it in a one-line buffer. Later fetches that fall in the same line are then answered from the buffer without any bus traffic.

The buffer holds one line, its line-address tag and a valid flag. A line stays usable until the next fill replaces it or a global invalidate clears it. A fill fetches the requested word first and then wraps through the rest of the line. The requester gets its word as soon as that first beat lands, but no new request is accepted until the line is complete. Every other read is passed to the bus as a single beat and leaves the buffer alone.

Top module: `ifetch_nc_linebuf`

## Requirements
- R1: With `fb_enable` low, an accepted read makes one single bus beat (`bus_burst` = 0) and never a burst.
- R2: A data read (`req_instr` = 0) never uses the buffer. It is done as one single bus beat even when its line is buffered.
- R3: A read whose `req_ttype` is not 0 never uses the buffer. It is done as one single bus beat even when its line is buffered.
- R4: A qualifying read that misses makes exactly WORDS bus beats with `bus_burst` = 1. The first beat address is the requested word, and the following beats step up by one word and wrap inside the line.
- R5: On a fill, `rsp_valid` rises one cycle after the bus acknowledges the requested word and carries that word. `req_ready` stays low until the last beat has been taken.
- R6: A qualifying read that hits the buffer returns the buffered word with `rsp_valid` one cycle after acceptance, and makes no bus request.
- R7: A new fill replaces the buffered line, so a read of the previous line misses and fills again.
- R8: `inval_all` clears the buffer. If it is pulsed while a fill is running, that line is not marked valid, and the next read of it fills again.
- R9: A non-buffered read puts its exact byte address on `bus_addr` and returns the bus data one cycle after the acknowledge. The buffered line stays valid and correct.
- R10: After reset, `req_ready` = 1, `bus_req` = 0, `rsp_valid` = 0, and the buffer holds no valid line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fb_enable | input | 1 | Enables line buffering of inhibited instruction reads |
| inval_all | input | 1 | Global invalidate pulse |
| req_valid | input | 1 | Read request valid |
| req_ready | output | 1 | Block can accept a request |
| req_addr | input | AW | Byte address of the read |
| req_instr | input | 1 | 1 = instruction fetch, 0 = data read |
| req_ttype | input | TTW | Transfer type; 0 = normal |
| rsp_valid | output | 1 | One-cycle pulse: read data is valid |
| rsp_data | output | DW | Read data |
| bus_req | output | 1 | External bus access in progress |
| bus_burst | output | 1 | 1 = line burst, 0 = single beat |
| bus_addr | output | AW | Address of the current beat |
| bus_ack | input | 1 | Beat accepted, data on `bus_rdata` |
| bus_rdata | input | DW | Beat read data |

## Verification
A buffer hit is due exactly one cycle after the accepting edge. With a zero-wait bus, fills and single reads are due two cycles after acceptance, which is one cycle after the acknowledging beat. With added wait states the due cycle moves later by exactly the wait count. The bench drives on falling edges and counts falling edges from the accepting edge until `rsp_valid` appears, then compares that count with the due cycle. It checks beat counts and addresses only after `req_ready` has come back, so the trailing beats of a fill are always included.

// File: rtl/ilb_pkg.sv
package ilb_pkg;
   typedef enum logic [1:0] {
      ST_IDLE   = 2'd0,
      ST_FILL   = 2'd1,
      ST_SINGLE = 2'd2
   } ilb_state_e;
endpackage

// File: rtl/ilb_qualify.sv
module ilb_qualify #(
   parameter int AW   = 32,
   parameter int TTW  = 2,
   parameter int OFFB = 4
) (
   input  logic            fb_enable,
   input  logic            req_instr,
   input  logic [TTW-1:0]  req_ttype,
   input  logic [AW-1:0]   req_addr,
   input  logic            buf_valid,
   input  logic [AW-OFFB-1:0] buf_tag,
   output logic            qual,
   output logic            hit
);
   localparam int TAGW = AW - OFFB;

   logic normal_tt;
   logic tag_eq;

   assign normal_tt = (req_ttype == '0);
   assign qual      = fb_enable & req_instr & normal_tt;
   assign tag_eq    = (req_addr[AW-1:OFFB] == buf_tag[TAGW-1:0]);
   assign hit       = qual & buf_valid & tag_eq;
endmodule

// File: rtl/ilb_line_store.sv
module ilb_line_store #(
   parameter int DW    = 32,
   parameter int WORDS = 4,
   parameter int TAGW  = 28
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     wr_en,
   input  logic [$clog2(WORDS)-1:0] wr_idx,
   input  logic [DW-1:0]            wr_data,
   input  logic                     fill_start,
   input  logic [TAGW-1:0]          fill_tag,
   input  logic                     fill_done,
   input  logic                     inval,
   input  logic [$clog2(WORDS)-1:0] rd_idx,
   output logic [DW-1:0]            rd_data,
   output logic                     buf_valid,
   output logic [TAGW-1:0]          buf_tag
);
   localparam int WIDX = $clog2(WORDS);

   logic [DW-1:0] word_q [WORDS];

   for (genvar i = 0; i < WORDS; i++) begin : g_word
      logic [DW-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            q <= '0;
         else if (wr_en && (wr_idx == WIDX'(i)))
            q <= wr_data;
      end
      assign word_q[i] = q;
   end

   assign rd_data = word_q[rd_idx];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         buf_valid <= 1'b0;
         buf_tag   <= '0;
      end else begin
         if (fill_start)
            buf_tag <= fill_tag;
         if (inval || fill_start)
            buf_valid <= 1'b0;
         else if (fill_done)
            buf_valid <= 1'b1;
      end
   end

   a_r8_inval_clears: assert property (@(posedge clk) disable iff (!rst_n)
      inval |=> !buf_valid);

   a_r7_fill_drops_old: assert property (@(posedge clk) disable iff (!rst_n)
      fill_start |=> !buf_valid);
endmodule

// File: rtl/ilb_sequencer.sv
module ilb_sequencer
   import ilb_pkg::*;
#(
   parameter int AW        = 32,
   parameter int DW        = 32,
   parameter int WORDS     = 4,
   parameter bit WRAP_FILL = 1'b1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     req_valid,
   input  logic [AW-1:0]            req_addr,
   input  logic                     qual,
   input  logic                     hit,
   input  logic                     inval,
   input  logic                     bus_ack,
   input  logic [DW-1:0]            bus_rdata,
   input  logic [DW-1:0]            buf_rdata,
   output logic                     req_ready,
   output logic                     rsp_valid,
   output logic [DW-1:0]            rsp_data,
   output logic                     bus_req,
   output logic                     bus_burst,
   output logic [AW-1:0]            bus_addr,
   output logic                     st_wr_en,
   output logic [$clog2(WORDS)-1:0] st_wr_idx,
   output logic [DW-1:0]            st_wr_data,
   output logic                     fill_start,
   output logic [AW-$clog2(WORDS)-$clog2(DW/8)-1:0] fill_tag,
   output logic                     fill_done,
   output logic [$clog2(WORDS)-1:0] rd_idx
);
   localparam int BYTEB = $clog2(DW/8);
   localparam int WIDX  = $clog2(WORDS);
   localparam int OFFB  = WIDX + BYTEB;

   ilb_state_e      state_q;
   logic [AW-1:0]   addr_q;
   logic [WIDX-1:0] word_q;
   logic [WIDX-1:0] crit_q;
   logic [WIDX-1:0] beat_cnt;
   logic            kill_q;
   logic [WIDX-1:0] req_word;
   logic [WIDX-1:0] start_word;
   logic            accept;
   logic            beat;
   logic            last_beat;

   assign req_word = req_addr[OFFB-1:BYTEB];

   if (WRAP_FILL) begin : g_crit_first
      assign start_word = req_word;
   end else begin : g_linear
      assign start_word = '0;
   end

   assign req_ready  = (state_q == ST_IDLE) && !rsp_valid;
   assign accept     = req_valid && req_ready;
   assign rd_idx     = req_word;
   assign fill_start = accept && qual && !hit;
   assign fill_tag   = req_addr[AW-1:OFFB];

   assign bus_req    = (state_q != ST_IDLE);
   assign bus_burst  = (state_q == ST_FILL);
   assign bus_addr   = bus_burst ? {addr_q[AW-1:OFFB], word_q, {BYTEB{1'b0}}} : addr_q;

   assign beat       = bus_req && bus_ack;
   assign last_beat  = (beat_cnt == WIDX'(WORDS - 1));
   assign st_wr_en   = bus_burst && beat;
   assign st_wr_idx  = word_q;
   assign st_wr_data = bus_rdata;
   assign fill_done  = st_wr_en && last_beat && !kill_q && !inval;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         addr_q    <= '0;
         word_q    <= '0;
         crit_q    <= '0;
         beat_cnt  <= '0;
         kill_q    <= 1'b0;
         rsp_valid <= 1'b0;
         rsp_data  <= '0;
      end else begin
         rsp_valid <= 1'b0;
         case (state_q)
            ST_IDLE: begin
               if (accept) begin
                  addr_q   <= req_addr;
                  word_q   <= start_word;
                  crit_q   <= req_word;
                  beat_cnt <= '0;
                  kill_q   <= inval;
                  if (hit) begin
                     rsp_valid <= 1'b1;
                     rsp_data  <= buf_rdata;
                  end else if (qual) begin
                     state_q <= ST_FILL;
                  end else begin
                     state_q <= ST_SINGLE;
                  end
               end
            end
            ST_FILL: begin
               if (inval)
                  kill_q <= 1'b1;
               if (beat) begin
                  word_q   <= word_q + 1'b1;
                  beat_cnt <= beat_cnt + 1'b1;
                  if (word_q == crit_q) begin
                     rsp_valid <= 1'b1;
                     rsp_data  <= bus_rdata;
                  end
                  if (last_beat)
                     state_q <= ST_IDLE;
               end
            end
            ST_SINGLE: begin
               if (beat) begin
                  rsp_valid <= 1'b1;
                  rsp_data  <= bus_rdata;
                  state_q   <= ST_IDLE;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   a_r4_burst_length: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_burst && bus_ack && (beat_cnt == WIDX'(WORDS - 1))) |=> !bus_req);

   a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid);

   a_r9_single_beat: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && !bus_burst && bus_ack) |=> (!bus_req && rsp_valid));
endmodule

// File: rtl/ifetch_nc_linebuf.sv
module ifetch_nc_linebuf #(
   parameter int AW        = 32,
   parameter int DW        = 32,
   parameter int WORDS     = 4,
   parameter int TTW       = 2,
   parameter bit WRAP_FILL = 1'b1
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           fb_enable,
   input  logic           inval_all,
   input  logic           req_valid,
   output logic           req_ready,
   input  logic [AW-1:0]  req_addr,
   input  logic           req_instr,
   input  logic [TTW-1:0] req_ttype,
   output logic           rsp_valid,
   output logic [DW-1:0]  rsp_data,
   output logic           bus_req,
   output logic           bus_burst,
   output logic [AW-1:0]  bus_addr,
   input  logic           bus_ack,
   input  logic [DW-1:0]  bus_rdata
);
   localparam int BYTEB = $clog2(DW/8);
   localparam int WIDX  = $clog2(WORDS);
   localparam int OFFB  = WIDX + BYTEB;
   localparam int TAGW  = AW - OFFB;

   if (WORDS < 2 || (WORDS & (WORDS - 1)) != 0) begin : g_bad_words
      $error("WORDS must be a power of two, at least 2");
   end
   if (DW < 16 || (DW % 8) != 0 || ((DW / 8) & (DW / 8 - 1)) != 0) begin : g_bad_dw
      $error("DW must be a power-of-two number of bytes, at least 16 bits");
   end
   if (TAGW < 1 || TTW < 1) begin : g_bad_aw
      $error("AW too small for the line size, or TTW is zero");
   end

   logic            qual;
   logic            hit;
   logic            buf_valid;
   logic [TAGW-1:0] buf_tag;
   logic [DW-1:0]   buf_rdata;
   logic            st_wr_en;
   logic [WIDX-1:0] st_wr_idx;
   logic [DW-1:0]   st_wr_data;
   logic            fill_start;
   logic [TAGW-1:0] fill_tag;
   logic            fill_done;
   logic [WIDX-1:0] rd_idx;

   ilb_qualify #(.AW(AW), .TTW(TTW), .OFFB(OFFB)) u_qual (
      .fb_enable (fb_enable),
      .req_instr (req_instr),
      .req_ttype (req_ttype),
      .req_addr  (req_addr),
      .buf_valid (buf_valid),
      .buf_tag   (buf_tag),
      .qual      (qual),
      .hit       (hit)
   );

   ilb_line_store #(.DW(DW), .WORDS(WORDS), .TAGW(TAGW)) u_store (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (st_wr_en),
      .wr_idx     (st_wr_idx),
      .wr_data    (st_wr_data),
      .fill_start (fill_start),
      .fill_tag   (fill_tag),
      .fill_done  (fill_done),
      .inval      (inval_all),
      .rd_idx     (rd_idx),
      .rd_data    (buf_rdata),
      .buf_valid  (buf_valid),
      .buf_tag    (buf_tag)
   );

   ilb_sequencer #(.AW(AW), .DW(DW), .WORDS(WORDS), .WRAP_FILL(WRAP_FILL)) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .req_valid  (req_valid),
      .req_addr   (req_addr),
      .qual       (qual),
      .hit        (hit),
      .inval      (inval_all),
      .bus_ack    (bus_ack),
      .bus_rdata  (bus_rdata),
      .buf_rdata  (buf_rdata),
      .req_ready  (req_ready),
      .rsp_valid  (rsp_valid),
      .rsp_data   (rsp_data),
      .bus_req    (bus_req),
      .bus_burst  (bus_burst),
      .bus_addr   (bus_addr),
      .st_wr_en   (st_wr_en),
      .st_wr_idx  (st_wr_idx),
      .st_wr_data (st_wr_data),
      .fill_start (fill_start),
      .fill_tag   (fill_tag),
      .fill_done  (fill_done),
      .rd_idx     (rd_idx)
   );

   a_r6_hit_no_bus: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready && hit) |=> (rsp_valid && !bus_req));

   a_r1_disabled_no_burst: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready && !fb_enable) |=> !bus_burst);

   a_r2_data_no_burst: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready && !req_instr) |=> !bus_burst);
endmodule

// File: tb/ifetch_nc_linebuf_bench.sv
`timescale 1ns/1ps
module ifetch_nc_linebuf_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        fb_enable = 1'b0;
   logic        inval_all = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [31:0] req_addr = '0;
   logic        req_instr = 1'b0;
   logic [1:0]  req_ttype = '0;
   logic        rsp_valid;
   logic [31:0] rsp_data;
   logic        bus_req;
   logic        bus_burst;
   logic [31:0] bus_addr;
   logic        bus_ack = 1'b0;
   logic [31:0] bus_rdata = '0;

   int checks = 0;
   int errors = 0;
   int beats = 0;
   int wait_cfg = 0;
   int wcnt = 0;
   logic [31:0] log_addr [256];
   logic        log_burst [256];

   always #2.5 clk = ~clk;

   ifetch_nc_linebuf u_ifetch_nc_linebuf (
      .clk(clk), .rst_n(rst_n), .fb_enable(fb_enable), .inval_all(inval_all),
      .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
      .req_instr(req_instr), .req_ttype(req_ttype), .rsp_valid(rsp_valid),
      .rsp_data(rsp_data), .bus_req(bus_req), .bus_burst(bus_burst),
      .bus_addr(bus_addr), .bus_ack(bus_ack), .bus_rdata(bus_rdata)
   );

   function automatic logic [31:0] memf(input logic [31:0] a);
      logic [31:0] w;
      w = {a[31:2], 2'b00};
      return {w[15:0] ^ 16'h5A3C, w[15:0]};
   endfunction

   // bus model: acknowledge after wait_cfg idle cycles per beat
   always @(negedge clk) begin
      if (!rst_n || !bus_req) begin
         bus_ack = 1'b0;
         wcnt = 0;
      end else if (wcnt >= wait_cfg) begin
         bus_ack = 1'b1;
         bus_rdata = memf(bus_addr);
         if (beats < 256) begin
            log_addr[beats] = bus_addr;
            log_burst[beats] = bus_burst;
         end
         beats = beats + 1;
         wcnt = 0;
      end else begin
         bus_ack = 1'b0;
         wcnt = wcnt + 1;
      end
   end

   task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic rd(input logic [31:0] a, input logic en, input logic ins, input logic [1:0] tt,
                     output logic [31:0] data, output int lat, output int nb,
                     output logic burst, output logic [31:0] faddr, output logic rdy_at_rsp);
      int b0;
      int g;
      b0 = beats;
      @(negedge clk);
      fb_enable = en; req_instr = ins; req_ttype = tt; req_addr = a; req_valid = 1'b1;
      g = 0;
      while (!req_ready && g < 200) begin @(negedge clk); g++; end
      @(posedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      lat = 1;
      while (!rsp_valid && lat < 200) begin @(negedge clk); lat++; end
      data = rsp_data;
      rdy_at_rsp = req_ready;
      g = 0;
      while (!req_ready && g < 200) begin @(negedge clk); g++; end
      nb = beats - b0;
      burst = (nb > 0) ? log_burst[b0] : 1'b0;
      faddr = (nb > 0) ? log_addr[b0] : 32'h0;
   endtask

   // {addr, enable, instr, ttype, expected beats}
   localparam logic [39:0] VEC [12] = '{
      {32'h0000_1000, 1'b1, 1'b1, 2'd0, 4'd4},
      {32'h0000_100C, 1'b1, 1'b1, 2'd0, 4'd0},
      {32'h0000_1004, 1'b1, 1'b1, 2'd0, 4'd0},
      {32'h0000_1010, 1'b1, 1'b1, 2'd0, 4'd4},
      {32'h0000_1000, 1'b1, 1'b1, 2'd0, 4'd4},
      {32'h0000_1008, 1'b1, 1'b1, 2'd1, 4'd1},
      {32'h0000_1008, 1'b1, 1'b0, 2'd0, 4'd1},
      {32'h0000_1008, 1'b0, 1'b1, 2'd0, 4'd1},
      {32'h0000_1008, 1'b1, 1'b1, 2'd0, 4'd0},
      {32'h0000_200C, 1'b1, 1'b1, 2'd0, 4'd4},
      {32'h0000_2000, 1'b1, 1'b1, 2'd0, 4'd0},
      {32'h0000_2008, 1'b1, 1'b1, 2'd0, 4'd0}
   };

   function automatic string tag_of(input int i);
      case (i)
         3, 4: return "R7";
         5:    return "R3";
         6:    return "R2";
         7:    return "R1";
         8:    return "R9";
         default: return (VEC[i][3:0] == 4'd0) ? "R6" : "R4";
      endcase
   endfunction

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [31:0] d;
      logic [31:0] fa;
      logic b;
      logic rr;
      int lat;
      int nb;

      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R10 reset state
      chk(req_ready == 1'b1, "R10 ready", {31'd0, req_ready}, 32'd1);
      chk(bus_req == 1'b0, "R10 bus_req", {31'd0, bus_req}, 32'd0);
      chk(rsp_valid == 1'b0, "R10 rsp_valid", {31'd0, rsp_valid}, 32'd0);

      for (int i = 0; i < 12; i++) begin
         logic [31:0] va;
         int en;
         va = VEC[i][39:8];
         rd(va, VEC[i][7], VEC[i][6], VEC[i][5:4], d, lat, nb, b, fa, rr);
         en = int'(VEC[i][3:0]);
         chk(d == memf(va), {tag_of(i), " data"}, d, memf(va));
         chk(nb == en, {tag_of(i), " beats"}, nb, en);
         chk(lat == ((en == 0) ? 1 : 2), {tag_of(i), " latency R5/R6"}, lat, (en == 0) ? 1 : 2);
         if (en == 4) begin
            chk(b == 1'b1, {tag_of(i), " burst R4"}, {31'd0, b}, 32'd1);
            chk(fa == va, "R4 critical first address", fa, va);
            chk(rr == 1'b0, "R5 ready low during fill", {31'd0, rr}, 32'd0);
         end
         if (en == 1) begin
            chk(b == 1'b0, {tag_of(i), " single beat"}, {31'd0, b}, 32'd0);
            chk(fa == va, "R9 exact address", fa, va);
         end
      end

      // R4 wrap order of the 0x200C burst
      chk(log_addr[beats-1] == 32'h0000_2008, "R4 wrap last beat", log_addr[beats-1], 32'h0000_2008);

      // R8 global invalidate while idle
      @(negedge clk); inval_all = 1'b1;
      @(negedge clk); inval_all = 1'b0;
      rd(32'h0000_2004, 1'b1, 1'b1, 2'd0, d, lat, nb, b, fa, rr);
      chk(nb == 4, "R8 refill after invalidate", nb, 4);
      chk(d == memf(32'h0000_2004), "R8 data", d, memf(32'h0000_2004));

      // R8 invalidate during a fill, with wait states
      wait_cfg = 2;
      fork
         rd(32'h0000_3000, 1'b1, 1'b1, 2'd0, d, lat, nb, b, fa, rr);
         begin
            repeat (4) @(negedge clk);
            inval_all = 1'b1;
            @(negedge clk);
            inval_all = 1'b0;
         end
      join
      chk(nb == 4, "R8 killed fill beats", nb, 4);
      chk(lat == 4, "R5 latency with waits", lat, 4);
      chk(d == memf(32'h0000_3000), "R5 critical data", d, memf(32'h0000_3000));
      rd(32'h0000_3004, 1'b1, 1'b1, 2'd0, d, lat, nb, b, fa, rr);
      chk(nb == 4, "R8 line not valid after killed fill", nb, 4);
      rd(32'h0000_300C, 1'b1, 1'b1, 2'd0, d, lat, nb, b, fa, rr);
      chk(nb == 0, "R6 hit after waited fill", nb, 0);
      chk(d == memf(32'h0000_300C), "R6 wrapped word data", d, memf(32'h0000_300C));
      wait_cfg = 0;

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule